// File: doc/BRIEF.md
# Supervisor Reset Pulse Generator

This block produces the system reset for a processor. It watches two inputs: a digital supply-good flag from an external undervoltage comparator, and an active-low pushbutton reset line. Reset is raised while the supply is reported bad or the button is pressed. It is held for a minimum number of clock cycles after both conditions have gone away, and only then released. Both polarities of reset are driven, and they are always exact complements.

Both inputs pass through a flop synchroniser before use. A hold counter reloads in every cycle in which either cause is present, and counts down only while both are absent. Because of this, a brownout during a running reset restarts the hold period. Contact bounce on the button merges into one pulse, and every reset pulse lasts at least the hold length. The hold length is a parameter in clock cycles, so a short value can be used for simulation.

Top module: `sys_reset_seq`

## Requirements
- R1: While `por_n` is low, `rst_out` is 1 and `rst_out_n` is 0. Release of `por_n` is handled as if the supply had just become good: `rst_out` falls at the (HOLD_CYCLES+2)-th rising clock edge after the edge that precedes the release.
- R2: `rst_out_n` equals the inverse of `rst_out` in every cycle.
- R3: When `supply_ok` goes to 0 after clock edge k, `rst_out` is 1 from edge k+3 onward and stays 1 for as long as `supply_ok` stays 0.
- R4: When `mr_n` goes to 0 after clock edge k, `rst_out` is 1 from edge k+3 onward and stays 1 for as long as `mr_n` stays 0.
- R5: When the last active cause clears after edge k, `rst_out` falls at edge k+2+HOLD_CYCLES. That is two synchroniser edges plus HOLD_CYCLES countdown edges, with no cause seen during that window.
- R6: A supply drop during the hold period restarts it. The release then follows R5, counted from the supply's recovery, and `rst_out` does not drop in between.
- R7: Low pulses on `mr_n` separated by gaps shorter than HOLD_CYCLES produce a single reset pulse. It is released per R5, counted from the final return of `mr_n` to 1.
- R8: When both causes overlap, the release is counted from whichever clears later.
- R9: A cause that arrives at the end of the hold period has exact timing. If it goes active after edge r-3, where r is the release edge, reset does not fall at r. If it goes active after edge r-2, `rst_out` falls at r and rises again at r+1.
- R10: Every reset pulse lasts at least HOLD_CYCLES cycles. A one-cycle low pulse on `mr_n` after edge k gives a pulse from edge k+3 to edge k+3+HOLD_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| por_n | input | 1 | Asynchronous power-on reset of the block, active low |
| supply_ok | input | 1 | Supply-good flag from the comparator, 1 = above threshold |
| mr_n | input | 1 | Manual reset request, active low, may bounce |
| rst_out | output | 1 | System reset, active high |
| rst_out_n | output | 1 | System reset, active low |

## Verification
Two of the block's functions can land in the same cycle: the hold countdown reaching its last step, and a new cause arriving through the synchroniser. The bench provokes this by scheduling a supply drop or a button press exactly three edges before the predicted release, and again two edges before it. In the first case, the scoreboard must see no falling edge at the predicted cycle. In the second, it must see a one-cycle release followed by a reassertion at the next edge, with both edges at their computed cycle numbers.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Decoded reset causes after synchronisation
  typedef struct packed {
    logic supply_low;
    logic manual;
  } cause_t;

  // Counter width able to hold the value 'hold'
  function automatic int count_bits(int unsigned hold);
    return (hold < 2) ? 1 : $clog2(hold + 1);
  endfunction

  function automatic logic cause_active(cause_t c);
    return c.supply_low | c.manual;
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stg <= {STAGES{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/rstseq_hold.sv
module rstseq_hold
  import rstseq_pkg::*;
#(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cause,
  output logic rst_q,
  output logic hold_zero
);

  localparam int CW = count_bits(HOLD);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;

  // Reload on any cause, otherwise step towards zero and stay there
  function automatic logic [CW-1:0] next_count(logic [CW-1:0] cur, logic active);
    if (active)        return LOAD;
    else if (cur == '0) return '0;
    else               return cur - 1'b1;
  endfunction

  assign cnt_nxt   = next_count(cnt, cause);
  assign hold_zero = (cnt == '0);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt   <= LOAD;
      rst_q <= 1'b1;
    end else begin
      cnt   <= cnt_nxt;
      rst_q <= (cnt_nxt != '0);
    end
  end

endmodule

// File: rtl/sys_reset_seq.sv
module sys_reset_seq
  import rstseq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic mr_n,
  output logic rst_out,
  output logic rst_out_n
);

  localparam int unsigned NIN = 2;
  // bit 1: supply_ok (resets to bad), bit 0: mr_n (resets to released)
  localparam logic [NIN-1:0] SYNC_RST = 2'b01;

  logic [NIN-1:0] raw_in;
  logic [NIN-1:0] sync_in;
  cause_t         causes;
  logic           cause_any;
  logic           rst_q;
  logic           hold_zero;

  assign raw_in = {supply_ok, mr_n};

  rstseq_sync #(
    .WIDTH  (NIN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .arst_n(por_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  assign causes.supply_low = ~sync_in[1];
  assign causes.manual     = ~sync_in[0];
  assign cause_any         = cause_active(causes);

  rstseq_hold #(
    .HOLD(HOLD_CYCLES)
  ) u_hold (
    .clk      (clk),
    .arst_n   (por_n),
    .cause    (cause_any),
    .rst_q    (rst_q),
    .hold_zero(hold_zero)
  );

  assign rst_out   = rst_q;
  assign rst_out_n = ~rst_q;

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk
  import rstseq_pkg::*;
#(
  parameter int unsigned HOLD = 16
) (
  input logic clk,
  input logic por_n,
  input logic cause_any,
  input logic rst_out
);

  localparam int CW = count_bits(HOLD);
  localparam logic [CW-1:0] LIM = CW'(HOLD);

  logic [CW-1:0] quiet_cnt;
  logic [CW-1:0] width_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      quiet_cnt <= '0;
      width_cnt <= '0;
    end else begin
      if (cause_any)          quiet_cnt <= '0;
      else if (quiet_cnt != LIM) quiet_cnt <= quiet_cnt + 1'b1;
      if (!rst_out)           width_cnt <= '0;
      else if (width_cnt != LIM) width_cnt <= width_cnt + 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!por_n) AST_POR_HOLDS: assert (rst_out); // R1
  end

  AST_CAUSE_FORCES: assert property (@(posedge clk) disable iff (!por_n)
    cause_any |=> rst_out); // R3

  AST_RELEASE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out) |-> (quiet_cnt >= LIM)); // R5

  AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out) |-> $past(cause_any)); // R9

  AST_MIN_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_out) |-> (width_cnt >= LIM)); // R10

endmodule

bind sys_reset_seq rstseq_chk #(.HOLD(HOLD_CYCLES)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .cause_any(cause_any),
  .rst_out  (rst_out)
);

// File: tb/tb_sys_reset_seq.sv
module tb_sys_reset_seq;
  localparam int H = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_ok = 1'b1;
  logic mr_n = 1'b1;
  logic rst_out, rst_out_n;

  sys_reset_seq #(.HOLD_CYCLES(H), .SYNC_STAGES(2)) dut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .mr_n(mr_n),
    .rst_out(rst_out), .rst_out_n(rst_out_n)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { bit rise; int at; string tag; } ev_t;
  ev_t exp_q[$];
  int total = 0, bad = 0;

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic expect_ev(bit rise, int at, string tag);
    ev_t e;
    e.rise = rise; e.at = at; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor: compares every reset edge against the scoreboard queue
  logic prev = 1'b1;
  always @(negedge clk) begin
    chk(rst_out_n == ~rst_out, "R2", "complement", int'(rst_out_n), int'(~rst_out));
    if (rst_out !== prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected edge at cycle", cyc, -1);
      end else begin
        ev_t e;
        e = exp_q.pop_front();
        chk(e.rise == rst_out, e.tag, "edge direction", int'(rst_out), int'(e.rise));
        chk(e.at == cyc, e.tag, "edge cycle", cyc, e.at);
      end
      prev = rst_out;
    end
  end

  initial begin
    #100000;
    chk(1'b0, "R5", "watchdog expired", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k, k2, r;
    // R1: power-on
    tick(3);
    chk(rst_out == 1'b1, "R1", "rst_out during por", int'(rst_out), 1);
    chk(rst_out_n == 1'b0, "R1", "rst_out_n during por", int'(rst_out_n), 0);
    k = cyc; por_n = 1'b1; expect_ev(0, k + 2 + H, "R1");
    tick(H + 6);

    // R3: supply drop and recovery
    k = cyc; supply_ok = 1'b0; expect_ev(1, k + 3, "R3");
    tick(30);
    chk(rst_out == 1'b1, "R3", "held while supply low", int'(rst_out), 1);
    k = cyc; supply_ok = 1'b1; expect_ev(0, k + 2 + H, "R5");
    tick(H + 6);

    // R4: manual reset
    k = cyc; mr_n = 1'b0; expect_ev(1, k + 3, "R4");
    tick(25);
    chk(rst_out == 1'b1, "R4", "held while button low", int'(rst_out), 1);
    k = cyc; mr_n = 1'b1; expect_ev(0, k + 2 + H, "R5");
    tick(H + 6);

    // R6: brownout during hold restarts it
    k = cyc; supply_ok = 1'b0; expect_ev(1, k + 3, "R6");
    tick(10); supply_ok = 1'b1;
    tick(8);  supply_ok = 1'b0;
    tick(3);  k = cyc; supply_ok = 1'b1; expect_ev(0, k + 2 + H, "R6");
    tick(H + 6);

    // R7: bouncing button merges into one pulse
    k = cyc; mr_n = 1'b0; expect_ev(1, k + 3, "R7");
    tick(2); mr_n = 1'b1;
    tick(3); mr_n = 1'b0;
    tick(1); mr_n = 1'b1;
    tick(4); mr_n = 1'b0;
    tick(2); k = cyc; mr_n = 1'b1; expect_ev(0, k + 2 + H, "R7");
    tick(H + 6);

    // R8: overlap, supply clears first
    k = cyc; supply_ok = 1'b0; expect_ev(1, k + 3, "R8");
    tick(5); mr_n = 1'b0;
    tick(5); supply_ok = 1'b1;
    tick(10); k = cyc; mr_n = 1'b1; expect_ev(0, k + 2 + H, "R8");
    tick(H + 6);
    // R8: overlap, button clears first
    k = cyc; mr_n = 1'b0; expect_ev(1, k + 3, "R8");
    tick(4); supply_ok = 1'b0;
    tick(4); mr_n = 1'b1;
    tick(12); k = cyc; supply_ok = 1'b1; expect_ev(0, k + 2 + H, "R8");
    tick(H + 6);

    // R9: cause arriving three edges before release keeps reset high
    k = cyc; supply_ok = 1'b0; expect_ev(1, k + 3, "R9");
    tick(5); k2 = cyc; supply_ok = 1'b1; r = k2 + 2 + H;
    tick(r - 3 - k2); supply_ok = 1'b0;
    tick(4); k = cyc; supply_ok = 1'b1; expect_ev(0, k + 2 + H, "R9");
    tick(H + 6);
    // R9: cause arriving two edges before release gives a one-cycle gap
    k = cyc; mr_n = 1'b0; expect_ev(1, k + 3, "R9");
    tick(5); k2 = cyc; mr_n = 1'b1; r = k2 + 2 + H; expect_ev(0, r, "R9");
    tick(r - 2 - k2); mr_n = 1'b0; expect_ev(1, r + 1, "R9");
    tick(4); k = cyc; mr_n = 1'b1; expect_ev(0, k + 2 + H, "R9");
    tick(H + 6);

    // R10: one-cycle button pulse still yields a full-width reset
    k = cyc; mr_n = 1'b0; expect_ev(1, k + 3, "R10");
    tick(1); mr_n = 1'b1; expect_ev(0, k + 3 + H, "R10");
    tick(H + 8);

    chk(exp_q.size() == 0, "R5", "pending expected edges", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule